// File: doc/BRIEF.md
# SMRAM Access Steering Controller

This chipset-side block decides, for every memory bus cycle, whether the access is served by the overlaid system-management RAM or by ordinary system RAM at the same physical address. The decision uses four things: the physical address, which master owns the bus (the processor or another master such as a DMA engine), the processor's system-management-active indication, and a software-controlled "open" bit. The open bit lets the management RAM be reached outside management mode, so that the handler can be loaded before it is first used.

The decoded region is aligned to its own size. Its size is a power of two of at least 32 KB, and it always contains the fixed 32 KB base range 38000h–3FFFFh. The top 512 bytes of that base range hold the saved processor state. A one-cycle flag reports processor writes that land there. A small generator turns a rising request edge into a one-clock SMI pulse. With overlaid management RAM, the cache-flush output pulses in that same clock.

Top module: `smram_steer_ctrl`

## Requirements
- R1: With `cfg_size_log2` = 15, the CPU as owner (`bus_is_cpu` = 1) and `smm_active` = 1, a valid cycle whose address is in 38000h..3FFFFh asserts `sel_smram` and not `sel_sysram`.
- R2: While `smm_active` = 1, a valid cycle from a non-CPU owner (`bus_is_cpu` = 0) always selects system RAM, even inside the window.
- R3: With `smm_active` = 0 and `cfg_open` = 1, a valid cycle from any owner inside the window selects SMRAM.
- R4: With `smm_active` = 0 and `cfg_open` = 0, every valid cycle selects system RAM.
- R5: With n = `cfg_size_log2`, clamped to 15 below and to 32 above, the window is the set of addresses whose bits [31:n] equal those of 38000h. For n = 32 that is the whole address space.
- R6: A valid cycle outside the window always selects system RAM.
- R7: The selects are combinational. While `cyc_valid` = 1 exactly one of them is high, and while `cyc_valid` = 0 both are low.
- R8: One clock after `smi_req` is first sampled high, following a low sample or reset, `smi_out` and `flush_out` are both high for exactly one clock. A held request gives no further pulse.
- R9: `save_wr_flag` is high for one clock after a cycle in which the CPU wrote, routed to SMRAM, to an address in 3FE00h..3FFFFh. It stays low after any other cycle.
- R10: In reset, `smi_out`, `flush_out` and `save_wr_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A memory bus cycle is present |
| cyc_addr | input | 32 | Physical address of the cycle |
| cyc_write | input | 1 | 1 = write cycle |
| bus_is_cpu | input | 1 | 1 = processor owns the bus, 0 = another master |
| smm_active | input | 1 | Processor is in system-management mode |
| cfg_open | input | 1 | Maps SMRAM into normal space outside management mode |
| cfg_size_log2 | input | 6 | log2 of the window size in bytes |
| smi_req | input | 1 | Request to raise an SMI |
| sel_smram | output | 1 | Route the cycle to management RAM |
| sel_sysram | output | 1 | Route the cycle to system RAM |
| smi_out | output | 1 | One-clock SMI pulse |
| flush_out | output | 1 | Cache-flush pulse, same clock as SMI |
| save_wr_flag | output | 1 | CPU wrote into the state-save area last cycle |

## Verification
The four window edges 37FFFh, 38000h, 3FFFFh and 40000h are driven under all eight combinations of owner, mode and open bit. This separates a wrong boundary from a wrong routing rule. Random addresses, clustered around the window and spread over the whole space, are combined with random size codes including out-of-range ones. They check the size-aligned decode and the clamping against an arithmetic model. The SMI and save-flag cases pair a held request with a fresh one, and a write just below 3FE00h with one at it. This catches level-triggered pulses and an off-by-one save boundary.

// File: rtl/smsteer_pkg.sv
`timescale 1ns/1ps
package smsteer_pkg;

    localparam int unsigned SM_ADDR_W     = 32;
    localparam int unsigned SM_MIN_LOG2   = 15;
    localparam int unsigned SM_SAVE_BYTES = 512;
    localparam logic [SM_ADDR_W-1:0] SM_BASE = 32'h0003_8000;

    typedef enum logic [1:0] {
        ROUTE_NONE   = 2'b00,
        ROUTE_SYSRAM = 2'b01,
        ROUTE_SMRAM  = 2'b10
    } sm_route_e;

    typedef struct packed {
        logic                 valid;
        logic                 write;
        logic                 cpu;
        logic [SM_ADDR_W-1:0] addr;
    } sm_cyc_t;

    function automatic logic sm_smram_allowed(input logic cpu, input logic smm,
                                              input logic open_bit);
        return smm ? cpu : open_bit;
    endfunction

endpackage

// File: rtl/smsteer_window.sv
`timescale 1ns/1ps
module smsteer_window #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned MIN_LOG2   = 15,
    parameter int unsigned SAVE_BYTES = 512,
    parameter logic [ADDR_W-1:0] BASE = '0,
    localparam int unsigned SZW       = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZW-1:0]    size_log2,
    output logic              in_window,
    output logic              in_save
);
    localparam logic [ADDR_W-1:0] BASE_END = BASE + ADDR_W'((64'd1 << MIN_LOG2) - 64'd1);
    localparam logic [ADDR_W-1:0] SAVE_LO  = BASE_END - ADDR_W'(SAVE_BYTES - 1);

    logic [SZW-1:0]    eff_log2;
    logic [ADDR_W-1:0] hi_mask;

    always_comb begin
        if (size_log2 < SZW'(MIN_LOG2))
            eff_log2 = SZW'(MIN_LOG2);
        else if (size_log2 > SZW'(ADDR_W))
            eff_log2 = SZW'(ADDR_W);
        else
            eff_log2 = size_log2;
    end

    for (genvar i = 0; i < int'(ADDR_W); i++) begin : g_mask
        assign hi_mask[i] = (eff_log2 <= SZW'(i));
    end

    assign in_window = (((addr ^ BASE) & hi_mask) == '0);
    assign in_save   = (addr >= SAVE_LO) && (addr <= BASE_END);

endmodule

// File: rtl/smsteer_route.sv
`timescale 1ns/1ps
module smsteer_route
    import smsteer_pkg::*;
(
    input  sm_cyc_t   cyc,
    input  logic      smm,
    input  logic      open_bit,
    input  logic      in_window,
    output sm_route_e route
);
    always_comb begin
        if (!cyc.valid)
            route = ROUTE_NONE;
        else if (in_window && sm_smram_allowed(cyc.cpu, smm, open_bit))
            route = ROUTE_SMRAM;
        else
            route = ROUTE_SYSRAM;
    end
endmodule

// File: rtl/smsteer_smi_gen.sv
`timescale 1ns/1ps
module smsteer_smi_gen #(
    parameter bit OVERLAID = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic smi,
    output logic flush
);
    logic req_q;
    logic smi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            smi_q <= 1'b0;
        end else begin
            req_q <= req;
            smi_q <= req && !req_q;
        end
    end

    assign smi = smi_q;

    if (OVERLAID) begin : g_flush
        logic flush_q;
        always_ff @(posedge clk) begin
            if (rst) flush_q <= 1'b0;
            else     flush_q <= req && !req_q;
        end
        assign flush = flush_q;

        AST_FLUSH_WITH_SMI: assert property (@(posedge clk) disable iff (rst)
            flush == smi); // R8
    end else begin : g_noflush
        assign flush = 1'b0;
    end

    AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        smi |=> !smi); // R8
    AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (rst)
        smi |-> $past(req)); // R8

endmodule

// File: rtl/smram_steer_ctrl.sv
`timescale 1ns/1ps
module smram_steer_ctrl
    import smsteer_pkg::*;
#(
    parameter bit OVERLAID = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cyc_valid,
    input  logic [SM_ADDR_W-1:0] cyc_addr,
    input  logic                 cyc_write,
    input  logic                 bus_is_cpu,
    input  logic                 smm_active,
    input  logic                 cfg_open,
    input  logic [5:0]           cfg_size_log2,
    input  logic                 smi_req,
    output logic                 sel_smram,
    output logic                 sel_sysram,
    output logic                 smi_out,
    output logic                 flush_out,
    output logic                 save_wr_flag
);
    sm_cyc_t   cyc;
    sm_route_e route;
    logic      in_window;
    logic      in_save;
    logic      save_q;

    assign cyc = '{valid: cyc_valid, write: cyc_write, cpu: bus_is_cpu, addr: cyc_addr};

    smsteer_window #(
        .ADDR_W(SM_ADDR_W), .MIN_LOG2(SM_MIN_LOG2),
        .SAVE_BYTES(SM_SAVE_BYTES), .BASE(SM_BASE)
    ) i_window (
        .addr(cyc_addr), .size_log2(cfg_size_log2),
        .in_window(in_window), .in_save(in_save)
    );

    smsteer_route i_route (
        .cyc(cyc), .smm(smm_active), .open_bit(cfg_open),
        .in_window(in_window), .route(route)
    );

    assign sel_smram  = (route == ROUTE_SMRAM);
    assign sel_sysram = (route == ROUTE_SYSRAM);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> $countones({sel_smram, sel_sysram}) == 1); // R7
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> !sel_smram && !sel_sysram); // R7
    AST_OTHER_MASTER_SYSRAM: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && smm_active && !bus_is_cpu |-> sel_sysram); // R2
    AST_CLOSED_SYSRAM: assert property (@(posedge clk) disable iff (rst)
        cyc_valid && !smm_active && !cfg_open |-> sel_sysram); // R4

    always_ff @(posedge clk) begin
        if (rst) save_q <= 1'b0;
        else     save_q <= sel_smram && cyc_write && bus_is_cpu && in_save;
    end
    assign save_wr_flag = save_q;

    AST_SAVE_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        save_wr_flag |-> $past(sel_smram && cyc_write && bus_is_cpu)); // R9

    smsteer_smi_gen #(.OVERLAID(OVERLAID)) i_smi (
        .clk(clk), .rst(rst), .req(smi_req), .smi(smi_out), .flush(flush_out)
    );

endmodule

// File: tb/test_smram_steer_ctrl.sv
`timescale 1ns/1ps
module test_smram_steer_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_valid, cyc_write, bus_is_cpu, smm_active, cfg_open, smi_req;
    logic [31:0] cyc_addr;
    logic [5:0]  cfg_size_log2;
    logic        sel_smram, sel_sysram, smi_out, flush_out, save_wr_flag;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    smram_steer_ctrl i_smram_steer_ctrl (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .bus_is_cpu(bus_is_cpu), .smm_active(smm_active),
        .cfg_open(cfg_open), .cfg_size_log2(cfg_size_log2), .smi_req(smi_req),
        .sel_smram(sel_smram), .sel_sysram(sel_sysram), .smi_out(smi_out),
        .flush_out(flush_out), .save_wr_flag(save_wr_flag)
    );

    function automatic bit model_in_window(logic [31:0] a, int unsigned sz);
        int unsigned n;
        logic [63:0] span, lo;
        n = (sz < 15) ? 15 : ((sz > 32) ? 32 : sz);
        span = 64'd1 << n;
        lo = (64'h38000 / span) * span;
        return ({32'd0, a} >= lo) && ({32'd0, a} < lo + span);
    endfunction

    function automatic bit model_smram(logic [31:0] a, bit cpu, bit smm, bit opn,
                                       int unsigned sz);
        if (!model_in_window(a, sz)) return 1'b0;       // R6
        if (smm) return cpu;                            // R1 R2
        return opn;                                     // R3 R4
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic route_case(string tag, logic [31:0] a, bit cpu, bit smm, bit opn,
                              int unsigned sz);
        bit e;
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b0; cyc_addr = a; bus_is_cpu = cpu;
        smm_active = smm; cfg_open = opn; cfg_size_log2 = 6'(sz);
        #1;
        e = model_smram(a, cpu, smm, opn, sz);
        chk(tag, {30'd0, sel_smram, sel_sysram}, {30'd0, e, !e});
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] edges [4];
        edges[0] = 32'h37FFF; edges[1] = 32'h38000; edges[2] = 32'h3FFFF; edges[3] = 32'h40000;
        void'($urandom(32'd20240611));
        rst = 1'b1; cyc_valid = 1'b0; cyc_write = 1'b0; cyc_addr = '0; bus_is_cpu = 1'b1;
        smm_active = 1'b0; cfg_open = 1'b0; cfg_size_log2 = 6'd15; smi_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 smi", {31'd0, smi_out}, 32'd0);
        chk("R10 flush", {31'd0, flush_out}, 32'd0);
        chk("R10 save", {31'd0, save_wr_flag}, 32'd0);
        rst = 1'b0;

        // R7 idle: no select
        @(negedge clk); cyc_valid = 1'b0; cyc_addr = 32'h38000; smm_active = 1'b1; #1;
        chk("R7 idle", {30'd0, sel_smram, sel_sysram}, 32'd0);

        // R1 R2 R3 R4 R6 edges for every owner/mode/open combination
        for (int c = 0; c < 8; c++)
            for (int k = 0; k < 4; k++)
                route_case("R1/R2/R3/R4/R6 edge", edges[k], c[0], c[1], c[2], 15);
        route_case("R1 base", 32'h38000, 1, 1, 0, 15);
        route_case("R2 dma", 32'h3C000, 0, 1, 1, 15);
        route_case("R3 open", 32'h38010, 0, 0, 1, 15);
        route_case("R4 closed", 32'h3FFFF, 1, 0, 0, 15);
        route_case("R5 size16", 32'h30000, 1, 1, 0, 16);
        route_case("R5 clamp low", 32'h37FFF, 1, 1, 0, 3);
        route_case("R5 full space", 32'hFFFF_FFF0, 1, 1, 0, 32);
        route_case("R5 clamp high", 32'h8000_0000, 1, 1, 0, 63);

        // R5 R6 random sweep
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            a = ($urandom % 2) ? (32'h30000 + ($urandom % 32'h20000)) : $urandom;
            route_case("R5/R6 random", a, 1'($urandom), 1'($urandom), 1'($urandom),
                       10 + ($urandom % 30));
        end

        // R9 save-area write flag
        @(negedge clk);
        cyc_valid = 1'b1; cyc_write = 1'b1; bus_is_cpu = 1'b1; smm_active = 1'b1;
        cfg_open = 1'b0; cfg_size_log2 = 6'd15; cyc_addr = 32'h3FE00;
        @(negedge clk);
        chk("R9 save hit", {31'd0, save_wr_flag}, 32'd1);
        cyc_addr = 32'h3FDFF;
        @(negedge clk);
        chk("R9 below save", {31'd0, save_wr_flag}, 32'd0);
        cyc_addr = 32'h3FFFF; bus_is_cpu = 1'b0;
        @(negedge clk);
        chk("R9 other master", {31'd0, save_wr_flag}, 32'd0);
        bus_is_cpu = 1'b1; cyc_write = 1'b0;
        @(negedge clk);
        chk("R9 read", {31'd0, save_wr_flag}, 32'd0);
        cyc_valid = 1'b0; cyc_write = 1'b0;

        // R8 SMI/flush pulse
        smi_req = 1'b1;
        @(negedge clk);
        chk("R8 smi pulse", {30'd0, smi_out, flush_out}, {30'd0, 2'b11});
        @(negedge clk);
        chk("R8 held req", {30'd0, smi_out, flush_out}, 32'd0);
        smi_req = 1'b0;
        @(negedge clk);
        chk("R8 low", {30'd0, smi_out, flush_out}, 32'd0);
        smi_req = 1'b1;
        @(negedge clk);
        chk("R8 second pulse", {30'd0, smi_out, flush_out}, {30'd0, 2'b11});
        smi_req = 1'b0;
        @(negedge clk);
        chk("R8 end", {30'd0, smi_out, flush_out}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule